// File: doc/BRIEF.md
# Dual-Policy Single-Line Write Cache Controller

This block is a one-line data cache placed between a processor request port and a next-level memory port. The line holds a valid flag, a modified flag, a block number and one data block. Every access moves a whole block at offset zero. Because there is a single set, the stored block number is the complete address.

A mode input selects how writes are handled. When it is high, the controller is write-back with write-allocate. When it is low, it is write-through with no-write-allocate. The mode is captured when a request is accepted and holds for the rest of that operation.

Reads that hit are answered from the line. Reads that miss fetch the block. A modified victim is always written out to the level below before the new block is fetched. The processor port drops its ready signal while any memory transfer is outstanding.

Top module: `wcache_ctrl`

## Requirements
- R1: After reset the line is invalid and unmodified, `cpu_ready` is 1 and `mem_req` is 0, so the first read of any block fetches it.
- R2: A read that hits raises `cpu_rvalid` for one cycle, one cycle after acceptance, with the cached block on `cpu_rdata`, and causes no memory transfer.
- R3: A read that misses on an invalid or unmodified line makes one fetch (`mem_we`=0, `mem_blk` = requested block). The fetched data is returned on `cpu_rdata` with `cpu_rvalid` in the cycle after the fetch is acknowledged. The line then holds that block.
- R4: A miss that replaces a modified line first writes the old data to the block number in the stored tag (`mem_we`=1). Only then does it fetch the new block, and the refilled line is unmodified.
- R5: In write-back mode (`wb_mode`=1), a write hit updates only the line and marks it modified, with no memory transfer.
- R6: In write-back mode, a write miss fetches the addressed block, evicting a modified victim first. It then applies the write-hit action, leaving the line modified with the written data.
- R7: In write-through mode (`wb_mode`=0), every write is sent to memory (`mem_we`=1, requested block, write data). On a hit, the cached copy is also updated.
- R8: In write-through mode, a write miss leaves the line's valid flag, tag and data unchanged.
- R9: The modified flag is never set by an operation accepted in write-through mode. A line written only in that mode is replaced without a write-back.
- R10: `mem_req`, `mem_we`, `mem_blk` and `mem_wdata` hold steady until a cycle with `mem_ack`=1. `cpu_ready` is 0 while `mem_req` is 1.
- R11: `wb_mode` is sampled only at request acceptance. Changing it while an operation is in progress does not alter that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back/write-allocate, 0 = write-through/no-write-allocate |
| cpu_req | input | 1 | Processor request, accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_blk | input | TAG_W | Block number of the request |
| cpu_wdata | input | DATA_W | Write data block |
| cpu_ready | output | 1 | Controller idle and able to accept |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | DATA_W | Read data block |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory, 0 = fetch |
| mem_blk | output | TAG_W | Memory block number |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_ack | input | 1 | Transfer completes at an edge where this is 1 |
| mem_rdata | input | DATA_W | Fetched block, valid with `mem_ack` |

## Verification
The bench builds the controller with TAG_W=4 and DATA_W=16. The 16-block memory model is therefore small enough to track in full, and every block number can be reused to force hits, clean and modified evictions, and victim data coming back through later reads. The memory model acknowledges after a latency that changes from one transfer to the next. This exercises both back-to-back eviction and fetch pairs and long waits while the processor port stays stalled. Mode changes are made both between requests and in the middle of an operation.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FETCH = 2'd2,
    ST_FWD   = 2'd3
  } cstate_t;

  // A replacement needs a write-back only when the line holds modified data
  function automatic logic must_evict(input logic valid, input logic dirty);
    return valid & dirty;
  endfunction

  // First state of a miss that brings a block into the line
  function automatic cstate_t miss_entry(input logic victim_dirty);
    return victim_dirty ? ST_EVICT : ST_FETCH;
  endfunction

endpackage

// File: rtl/wcache_line.sv
module wcache_line #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lookup_blk,
  output logic              hit,
  output logic              victim_dirty,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              upd_mark,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_blk,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_mark,
  input  logic              clean_en,
  output logic              valid,
  output logic              dirty,
  output logic [TAG_W-1:0]  tag,
  output logic [DATA_W-1:0] data
);
  import wcache_pkg::*;

  function automatic logic tag_match(input logic v, input logic [TAG_W-1:0] t,
                                     input logic [TAG_W-1:0] b);
    return v && (t == b);
  endfunction

  assign hit          = tag_match(valid, tag, lookup_blk);
  assign victim_dirty = must_evict(valid, dirty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dirty <= 1'b0;
      tag   <= '0;
      data  <= '0;
    end else if (fill_en) begin
      valid <= 1'b1;
      tag   <= fill_blk;
      data  <= fill_data;
      dirty <= fill_mark;
    end else begin
      if (upd_en) begin
        data <= upd_data;
        if (upd_mark) dirty <= 1'b1;
      end
      if (clean_en) dirty <= 1'b0;
    end
  end

endmodule

// File: rtl/wcache_fsm.sv
module wcache_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic                 wb_mode,
  input  logic                 hit,
  input  logic                 victim_dirty,
  input  logic                 mem_ack,
  output wcache_pkg::cstate_t  state,
  output logic                 ready,
  output logic                 accept,
  output logic                 mode_q
);
  import wcache_pkg::*;

  cstate_t nxt;

  assign ready  = (state == ST_IDLE);
  assign accept = ready & cpu_req;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (!cpu_we)      nxt = hit ? ST_IDLE : miss_entry(victim_dirty);
          else if (wb_mode) nxt = hit ? ST_IDLE : miss_entry(victim_dirty);
          else              nxt = ST_FWD;
        end
      end
      ST_EVICT: if (mem_ack) nxt = ST_FETCH;
      ST_FETCH: if (mem_ack) nxt = ST_IDLE;
      ST_FWD:   if (mem_ack) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= 1'b1;
    end else begin
      state <= nxt;
      if (accept) mode_q <= wb_mode;
    end
  end

endmodule

// File: rtl/wcache_memport.sv
module wcache_memport #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  wcache_pkg::cstate_t state,
  input  logic [TAG_W-1:0]    victim_tag,
  input  logic [DATA_W-1:0]   victim_data,
  input  logic [TAG_W-1:0]    req_blk,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [TAG_W-1:0]    mem_blk,
  output logic [DATA_W-1:0]   mem_wdata
);
  import wcache_pkg::*;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_blk   = req_blk;
    mem_wdata = req_wdata;
    unique case (state)
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_blk   = victim_tag;
        mem_wdata = victim_data;
      end
      ST_FETCH: mem_req = 1'b1;
      ST_FWD: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: mem_req = 1'b0;
    endcase
  end

endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_blk,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [TAG_W-1:0]  mem_blk,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import wcache_pkg::*;

  cstate_t           state;
  logic              ev_accept;
  logic              ev_hit;
  logic              ev_evict_done;
  logic              ev_fill_done;
  logic              mode_q;
  logic              victim_dirty;
  logic              line_valid;
  logic              line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              req_we_q;
  logic [TAG_W-1:0]  req_blk_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  logic              upd_en;
  logic              fill_en;
  logic [DATA_W-1:0] fill_data;

  wcache_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .wb_mode      (wb_mode),
    .hit          (ev_hit),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .state        (state),
    .ready        (cpu_ready),
    .accept       (ev_accept),
    .mode_q       (mode_q)
  );

  assign ev_evict_done = (state == ST_EVICT) && mem_ack;
  assign ev_fill_done  = (state == ST_FETCH) && mem_ack;

  // A hit write updates the copy in both modes; only write-back marks it
  assign upd_en    = ev_accept && cpu_we && ev_hit;
  assign fill_en   = ev_fill_done;
  assign fill_data = req_we_q ? req_wdata_q : mem_rdata;

  wcache_line #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_blk   (cpu_blk),
    .hit          (ev_hit),
    .victim_dirty (victim_dirty),
    .upd_en       (upd_en),
    .upd_data     (cpu_wdata),
    .upd_mark     (wb_mode),
    .fill_en      (fill_en),
    .fill_blk     (req_blk_q),
    .fill_data    (fill_data),
    .fill_mark    (req_we_q),
    .clean_en     (ev_evict_done),
    .valid        (line_valid),
    .dirty        (line_dirty),
    .tag          (line_tag),
    .data         (line_data)
  );

  wcache_memport #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_mem (
    .state       (state),
    .victim_tag  (line_tag),
    .victim_data (line_data),
    .req_blk     (req_blk_q),
    .req_wdata   (req_wdata_q),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_blk     (mem_blk),
    .mem_wdata   (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_we_q    <= 1'b0;
      req_blk_q   <= '0;
      req_wdata_q <= '0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (ev_accept) begin
        req_we_q    <= cpu_we;
        req_blk_q   <= cpu_blk;
        req_wdata_q <= cpu_wdata;
      end
      rvalid_q <= 1'b0;
      if (ev_accept && !cpu_we && ev_hit) begin
        rvalid_q <= 1'b1;
        rdata_q  <= line_data;
      end else if (ev_fill_done && !req_we_q) begin
        rvalid_q <= 1'b1;
        rdata_q  <= mem_rdata;
      end
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

endmodule

// File: rtl/wcache_ctrl_chk.sv
module wcache_ctrl_chk #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic              wb_mode,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [TAG_W-1:0]  mem_blk,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              ev_accept,
  input logic              ev_hit,
  input logic              mode_q,
  input logic              line_valid,
  input logic              line_dirty,
  input logic [TAG_W-1:0]  line_tag,
  input logic [DATA_W-1:0] line_data
);

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!line_valid && !line_dirty && cpu_ready && !mem_req));

  a_r2_read_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !cpu_we && ev_hit) |=> (cpu_rvalid && !mem_req));

  a_r4_fetch_after_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !line_dirty);

  a_r5_wb_hit_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && cpu_we && wb_mode && ev_hit) |=> (line_dirty && !mem_req && cpu_ready));

  a_r8_no_allocate: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && cpu_we && !wb_mode && !ev_hit) |=>
      ($stable(line_valid) && $stable(line_tag) && $stable(line_data)));

  a_r9_wt_never_marks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_dirty) |-> mode_q);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_we) && $stable(mem_blk) && $stable(mem_wdata)));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |=> $stable(mode_q));

endmodule

bind wcache_ctrl wcache_ctrl_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_we     (cpu_we),
  .wb_mode    (wb_mode),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_blk    (mem_blk),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .ev_accept  (ev_accept),
  .ev_hit     (ev_hit),
  .mode_q     (mode_q),
  .line_valid (line_valid),
  .line_dirty (line_dirty),
  .line_tag   (line_tag),
  .line_data  (line_data)
);

// File: tb/wcache_ctrl_tb.sv
`timescale 1ns/1ps
module wcache_ctrl_tb;
  localparam int TW = 4;
  localparam int DW = 16;
  localparam int NB = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wb_mode = 1'b1;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [TW-1:0] cpu_blk = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic          cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req;
  logic          mem_we;
  logic [TW-1:0] mem_blk;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wcache_ctrl #(.TAG_W(TW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_blk(cpu_blk), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_blk(mem_blk), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct {
    bit            we;
    logic [TW-1:0] blk;
    logic [DW-1:0] wd;
    string         rq;
  } mop_t;

  typedef struct {
    logic [DW-1:0] d;
    string         rq;
  } rd_t;

  mop_t mq[$];
  rd_t  rdq[$];

  // memory seen by the responder, and the bench's own expectation of it
  logic [DW-1:0] mem [NB];
  logic [DW-1:0] emem[NB];

  // reference line
  bit            m_valid = 0;
  bit            m_dirty = 0;
  logic [TW-1:0] m_tag = '0;
  logic [DW-1:0] m_data = '0;

  function automatic logic [DW-1:0] seed_val(input int i);
    return DW'(16'hA000 + i * 16'h0111);
  endfunction

  task automatic push_mem(input bit we, input logic [TW-1:0] b, input logic [DW-1:0] d,
                          input string rq);
    mop_t e;
    e.we = we; e.blk = b; e.wd = d; e.rq = rq;
    mq.push_back(e);
  endtask

  task automatic push_rd(input logic [DW-1:0] d, input string rq);
    rd_t e;
    e.d = d; e.rq = rq;
    rdq.push_back(e);
  endtask

  // bring block b into the reference line, writing back a modified victim first
  task automatic model_fill(input logic [TW-1:0] b, input string rq);
    if (m_valid && m_dirty) begin
      push_mem(1'b1, m_tag, m_data, rq);
      emem[m_tag] = m_data;
    end
    push_mem(1'b0, b, '0, rq);
    m_valid = 1; m_tag = b; m_data = emem[b]; m_dirty = 0;
  endtask

  task automatic do_req(input bit we, input logic [TW-1:0] b, input logic [DW-1:0] d,
                        input bit m, input string rq, input bit flip);
    bit hit;
    hit = m_valid && (m_tag == b);
    if (!we) begin
      if (!hit) model_fill(b, rq);
      push_rd(m_data, rq);
    end else if (m) begin
      if (!hit) model_fill(b, rq);
      m_data = d; m_dirty = 1;
    end else begin
      push_mem(1'b1, b, d, rq);
      emem[b] = d;
      if (hit) m_data = d;
    end
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_blk = b; cpu_wdata = d; wb_mode = m;
    @(negedge clk);
    cpu_req = 1'b0;
    if (flip) wb_mode = ~m;
  endtask

  // memory responder and scoreboard monitors
  int wait_cnt = 0;
  int lat = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt >= lat) begin
          checks++;
          if (mq.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected memory transfer: actual we=%0b blk=%0d expected none",
                     mem_we, mem_blk);
          end else begin
            mop_t e;
            e = mq.pop_front();
            if (e.we !== mem_we || e.blk !== mem_blk || (e.we && e.wd !== mem_wdata)) begin
              errors++;
              $display("FAIL %s memory op: actual we=%0b blk=%0d wd=%h expected we=%0b blk=%0d wd=%h",
                       e.rq, mem_we, mem_blk, mem_wdata, e.we, e.blk, e.wd);
            end
          end
          checks++;
          if (cpu_ready !== 1'b0) begin
            errors++;
            $display("FAIL R10 ready during transfer: actual=%0b expected=0", cpu_ready);
          end
          if (mem_we) mem[mem_blk] = mem_wdata;
          else        mem_rdata = mem[mem_blk];
          mem_ack  = 1'b1;
          wait_cnt = 0;
          lat      = (lat + 3) % 5;
        end else begin
          wait_cnt++;
        end
      end
    end
    if (cpu_rvalid === 1'b1) begin
      checks++;
      if (rdq.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data: actual=%h expected none", cpu_rdata);
      end else begin
        rd_t r;
        r = rdq.pop_front();
        if (r.d !== cpu_rdata) begin
          errors++;
          $display("FAIL %s read data: actual=%h expected=%h", r.rq, cpu_rdata, r.d);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      mem[i]  = seed_val(i);
      emem[i] = seed_val(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    checks++;
    if (cpu_ready !== 1'b1 || mem_req !== 1'b0 || cpu_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: actual ready=%0b req=%0b rvalid=%0b expected 1 0 0",
               cpu_ready, mem_req, cpu_rvalid);
    end
    do_req(0, 4'd3, '0, 1, "R1", 0);          // first read must fetch
    do_req(0, 4'd3, '0, 1, "R2", 0);          // read hit
    do_req(1, 4'd3, 16'h1111, 1, "R5", 0);    // write-back hit
    do_req(0, 4'd3, '0, 1, "R5", 0);          // hit returns new data
    do_req(0, 4'd5, '0, 1, "R4", 0);          // modified victim written first
    do_req(0, 4'd3, '0, 1, "R4", 0);          // victim data reached memory
    do_req(0, 4'd8, '0, 0, "R3", 0);          // clean miss in write-through mode
    do_req(1, 4'd7, 16'h2222, 1, "R6", 0);    // allocate on write miss
    do_req(0, 4'd9, '0, 0, "R6", 0);          // allocated line is modified
    do_req(1, 4'd9, 16'h4444, 0, "R7", 0);    // write-through hit forwarded
    do_req(0, 4'd9, '0, 0, "R7", 0);          // copy updated
    do_req(0, 4'd2, '0, 1, "R9", 0);          // no write-back of the line
    do_req(1, 4'd6, 16'h5555, 0, "R8", 0);    // no-allocate miss
    do_req(0, 4'd2, '0, 0, "R8", 0);          // line unchanged, still a hit
    do_req(0, 4'd6, '0, 1, "R8", 0);          // memory holds forwarded data
    do_req(1, 4'd10, 16'h6666, 1, "R11", 1);  // mode flipped while allocating
    do_req(0, 4'd11, '0, 1, "R11", 0);        // victim write-back proves allocation
    do_req(1, 4'd12, 16'h7777, 0, "R11", 1);  // mode flipped while forwarding
    do_req(0, 4'd11, '0, 0, "R11", 0);        // line kept by no-allocate
    do_req(0, 4'd12, '0, 1, "R10", 0);        // fetch of forwarded data
    repeat (30) @(negedge clk);
    checks++;
    if (mq.size() != 0 || rdq.size() != 0) begin
      errors++;
      $display("FAIL R10 pending expectations: actual mem=%0d rd=%0d expected 0 0",
               mq.size(), rdq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule